// File: doc/BRIEF.md
# Framed Serial Character Receiver

This block turns an asynchronous serial line into parallel characters. A one-cycle enable pulse, running at sixteen times the bit rate, paces the sampling. The block first checks that a start bit is real. It then collects 5 to 8 data bits, least significant bit first, takes an optional parity bit and checks one stop bit. Each finished character goes into a holding buffer, where the host reads it while the next character is still arriving.

For each character the block reports parity errors, framing errors and line breaks. It also reports an overrun when a new character replaces one that was never read. A loop-back select makes the receiver take its line from the local transmitter's serial output and ignore the external pin.

The frame settings (length, parity enable and parity sense) are captured when a start bit is detected, so changing them during a frame has no effect on that frame.

Top module: `serial_char_receiver`

## Requirements
- R1: `char_len` sets the number of data bits: 0 gives 5, 1 gives 6, 2 gives 7 and 3 gives 8. The first data bit received lands in `rx_data[0]`.
- R2: When a character is shorter than 8 bits, the bits of `rx_data` above its length read as 0.
- R3: Every bit lasts 16 `tick16` pulses. A low level seen on the idle line is confirmed at the eighth tick after it was detected. If the line is high again at that point, no character is produced.
- R4: When `par_en` is 1, one parity bit follows the data bits. The parity is odd when `par_odd` is 1 and even when it is 0. `parity_err` is set when the received parity does not match. When `par_en` is 0, no parity bit is expected and `parity_err` stays 0.
- R5: `frame_err` is set when the stop bit is sampled low.
- R6: `break_det` is set when every data bit, the parity bit (if enabled) and the stop bit are all sampled low. `frame_err` is set together with it.
- R7: `data_ready` rises in the cycle after a character completes. A one-cycle `rd_strobe` clears `data_ready`, `parity_err`, `frame_err`, `break_det` and `overrun` on the next clock edge. If a character completes in the same cycle as the read, the new character wins.
- R8: If a character completes while `data_ready` is still 1 and no read is made in that cycle, `overrun` is set and the buffer holds the newer character.
- R9: When `loop_en` is 1, the receiver takes its line from `loop_din` and ignores `rx_pin`.
- R10: A character in the buffer stays readable, unchanged, while the next character is shifting in.
- R11: After reset, `data_ready`, all the error flags and `rx_data` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick16 | input | 1 | Sampling enable pulse at 16 times the bit rate |
| rx_pin | input | 1 | External serial line, idle high |
| loop_en | input | 1 | Selects `loop_din` as the line |
| loop_din | input | 1 | Local transmitter serial output |
| char_len | input | 2 | Data length code (bits = 5 + code) |
| par_en | input | 1 | Parity bit present |
| par_odd | input | 1 | 1: odd parity, 0: even parity |
| rd_strobe | input | 1 | Host read of the buffer, one cycle |
| rx_data | output | 8 | Buffered character, zero-filled above its length |
| data_ready | output | 1 | Buffer holds an unread character |
| parity_err | output | 1 | Parity mismatch in the buffered character |
| frame_err | output | 1 | Stop bit was low |
| break_det | output | 1 | Whole frame sampled low |
| overrun | output | 1 | An unread character was replaced |

## Verification
Random frames mix all four lengths, parity off, even and odd, and any data value, with corrupted parity bits and low stop bits injected now and then. These separate errors in bit order, masking of the upper bits and parity sense. Directed frames cover the following cases:
- A short low pulse, which must be rejected.
- An all-zero frame, where a break has to be told apart from a plain framing error.
- Two unread characters in a row, which must raise an overrun.
- A read made while the next character is arriving, which shows the buffer is double.
- Loop-back mode with the external pin held low, which shows that pin has no effect.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;

   typedef enum logic [2:0] {
      RX_IDLE,
      RX_START,
      RX_DATA,
      RX_PAR,
      RX_STOP
   } rx_state_e;

   typedef struct packed {
      logic perr;
      logic ferr;
      logic brk;
   } rx_flags_t;

endpackage

// File: rtl/rx_line_select.sv
module rx_line_select #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin,
   input  logic loop_en,
   input  logic loop_din,
   output logic line_out
);

   logic sel;
   assign sel = loop_en ? loop_din : pin;

   generate
      if (SYNC_STAGES == 0) begin : g_direct
         assign line_out = sel;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] sr;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               sr <= '1;
            end else begin
               sr[0] <= sel;
               for (int i = 1; i < SYNC_STAGES; i++) sr[i] <= sr[i-1];
            end
         end
         assign line_out = sr[SYNC_STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/rx_bit_engine.sv
module rx_bit_engine
   import serial_rx_pkg::*;
#(
   parameter int OVS      = 16,
   parameter int MAX_BITS = 8,
   parameter int MIN_BITS = 5,
   parameter int LEN_W    = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                tick,
   input  logic                line,
   input  logic [LEN_W-1:0]    char_len,
   input  logic                par_en,
   input  logic                par_odd,
   output logic                done,
   output logic [MAX_BITS-1:0] word,
   output rx_flags_t           flags
);

   localparam int CNT_W = $clog2(OVS);
   localparam int IDX_W = $clog2(MAX_BITS + 1);
   localparam logic [CNT_W-1:0] MID  = CNT_W'(OVS / 2 - 1);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(OVS - 1);

   rx_state_e            state;
   logic [CNT_W-1:0]     cnt;
   logic [IDX_W-1:0]     idx;
   logic [MAX_BITS-1:0]  shreg;
   logic                 par_acc;
   logic                 all_low;
   logic [LEN_W-1:0]     lat_len;
   logic                 lat_pen;
   logic [IDX_W-1:0]     nbits;

   assign nbits = IDX_W'(MIN_BITS) + IDX_W'(lat_len);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= RX_IDLE;
         cnt     <= '0;
         idx     <= '0;
         shreg   <= '0;
         par_acc <= 1'b0;
         all_low <= 1'b0;
         lat_len <= '0;
         lat_pen <= 1'b0;
         done    <= 1'b0;
         word    <= '0;
         flags   <= '0;
      end else begin
         done <= 1'b0;
         if (tick) begin
            case (state)
               RX_IDLE: begin
                  if (!line) begin
                     state   <= RX_START;
                     cnt     <= '0;
                     lat_len <= char_len;
                     lat_pen <= par_en;
                     par_acc <= par_odd;
                  end
               end
               RX_START: begin
                  if (cnt == MID) begin
                     cnt <= '0;
                     if (!line) begin
                        state   <= RX_DATA;
                        idx     <= '0;
                        shreg   <= '0;
                        all_low <= 1'b1;
                     end else begin
                        state <= RX_IDLE;
                     end
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               RX_DATA: begin
                  if (cnt == LAST) begin
                     cnt     <= '0;
                     shreg   <= {line, shreg[MAX_BITS-1:1]};
                     par_acc <= par_acc ^ line;
                     all_low <= all_low & ~line;
                     if (idx == nbits - 1'b1) begin
                        state <= lat_pen ? RX_PAR : RX_STOP;
                     end else begin
                        idx <= idx + 1'b1;
                     end
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               RX_PAR: begin
                  if (cnt == LAST) begin
                     cnt     <= '0;
                     par_acc <= par_acc ^ line;
                     all_low <= all_low & ~line;
                     state   <= RX_STOP;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               RX_STOP: begin
                  if (cnt == LAST) begin
                     cnt        <= '0;
                     state      <= RX_IDLE;
                     done       <= 1'b1;
                     word       <= shreg >> (IDX_W'(MAX_BITS) - nbits);
                     flags.perr <= lat_pen & par_acc;
                     flags.ferr <= ~line;
                     flags.brk  <= all_low & ~line;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               default: state <= RX_IDLE;
            endcase
         end
      end
   end

endmodule

// File: rtl/rx_holding_buffer.sv
module rx_holding_buffer
   import serial_rx_pkg::*;
#(
   parameter int MAX_BITS = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                done,
   input  logic [MAX_BITS-1:0] word,
   input  rx_flags_t           flags_in,
   input  logic                rd,
   output logic [MAX_BITS-1:0] data,
   output logic                ready,
   output rx_flags_t           flags,
   output logic                ovr
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data  <= '0;
         ready <= 1'b0;
         flags <= '0;
         ovr   <= 1'b0;
      end else if (done) begin
         data  <= word;
         ready <= 1'b1;
         flags <= flags_in;
         ovr   <= rd ? 1'b0 : (ovr | ready);
      end else if (rd) begin
         ready <= 1'b0;
         flags <= '0;
         ovr   <= 1'b0;
      end
   end

endmodule

// File: rtl/serial_char_receiver.sv
module serial_char_receiver
   import serial_rx_pkg::*;
#(
   parameter int OVS         = 16,
   parameter int MAX_BITS    = 8,
   parameter int MIN_BITS    = 5,
   parameter int LEN_W       = 2,
   parameter int SYNC_STAGES = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                tick16,
   input  logic                rx_pin,
   input  logic                loop_en,
   input  logic                loop_din,
   input  logic [LEN_W-1:0]    char_len,
   input  logic                par_en,
   input  logic                par_odd,
   input  logic                rd_strobe,
   output logic [MAX_BITS-1:0] rx_data,
   output logic                data_ready,
   output logic                parity_err,
   output logic                frame_err,
   output logic                break_det,
   output logic                overrun
);

   generate
      if (OVS < 4 || (OVS % 2) != 0) begin : g_bad_ovs
         $error("OVS must be even and at least 4");
      end
      if (MIN_BITS + (1 << LEN_W) - 1 != MAX_BITS) begin : g_bad_len
         $error("length code range must end at MAX_BITS");
      end
      if (SYNC_STAGES < 0) begin : g_bad_sync
         $error("SYNC_STAGES must not be negative");
      end
   endgenerate

   logic                line;
   logic                eng_done;
   logic [MAX_BITS-1:0] eng_word;
   rx_flags_t           eng_flags;
   rx_flags_t           buf_flags;

   rx_line_select #(.SYNC_STAGES(SYNC_STAGES)) u_line (
      .clk      (clk),
      .rst_n    (rst_n),
      .pin      (rx_pin),
      .loop_en  (loop_en),
      .loop_din (loop_din),
      .line_out (line)
   );

   rx_bit_engine #(
      .OVS(OVS), .MAX_BITS(MAX_BITS), .MIN_BITS(MIN_BITS), .LEN_W(LEN_W)
   ) u_engine (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (tick16),
      .line     (line),
      .char_len (char_len),
      .par_en   (par_en),
      .par_odd  (par_odd),
      .done     (eng_done),
      .word     (eng_word),
      .flags    (eng_flags)
   );

   rx_holding_buffer #(.MAX_BITS(MAX_BITS)) u_buf (
      .clk      (clk),
      .rst_n    (rst_n),
      .done     (eng_done),
      .word     (eng_word),
      .flags_in (eng_flags),
      .rd       (rd_strobe),
      .data     (rx_data),
      .ready    (data_ready),
      .flags    (buf_flags),
      .ovr      (overrun)
   );

   assign parity_err = buf_flags.perr;
   assign frame_err  = buf_flags.ferr;
   assign break_det  = buf_flags.brk;

endmodule

// File: rtl/serial_char_receiver_chk.sv
module serial_char_receiver_chk #(
   parameter int MAX_BITS = 8,
   parameter int MIN_BITS = 5,
   parameter int LEN_W    = 2
) (
   input logic                clk,
   input logic                rst_n,
   input logic [LEN_W-1:0]    char_len,
   input logic                rd_strobe,
   input logic                eng_done,
   input logic [MAX_BITS-1:0] eng_word,
   input logic                data_ready,
   input logic                frame_err,
   input logic                break_det,
   input logic                overrun
);

   // R2
   upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      eng_done |-> ((eng_word >> (MIN_BITS + int'(char_len))) == '0));

   // R7
   rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_strobe && !eng_done) |=> !data_ready);

   // R7
   ready_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(data_ready) |-> $past(eng_done));

   // R8
   overrun_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (eng_done && data_ready && !rd_strobe) |=> overrun);

   // R6
   break_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
      break_det |-> frame_err);

endmodule

bind serial_char_receiver serial_char_receiver_chk #(
   .MAX_BITS(MAX_BITS), .MIN_BITS(MIN_BITS), .LEN_W(LEN_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .char_len   (char_len),
   .rd_strobe  (rd_strobe),
   .eng_done   (eng_done),
   .eng_word   (eng_word),
   .data_ready (data_ready),
   .frame_err  (frame_err),
   .break_det  (break_det),
   .overrun    (overrun)
);

// File: tb/serial_char_receiver_bench.sv
module serial_char_receiver_bench;

   localparam int BITCLK = 64;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick16 = 1'b0;
   logic       rx_pin = 1'b1;
   logic       loop_en = 1'b0;
   logic       loop_din = 1'b1;
   logic [1:0] char_len = 2'd3;
   logic       par_en = 1'b0;
   logic       par_odd = 1'b0;
   logic       rd_strobe = 1'b0;
   logic [7:0] rx_data;
   logic       data_ready, parity_err, frame_err, break_det, overrun;

   int checks = 0;
   int fails  = 0;
   bit ended  = 0;

   serial_char_receiver u_serial_char_receiver (
      .clk(clk), .rst_n(rst_n), .tick16(tick16), .rx_pin(rx_pin),
      .loop_en(loop_en), .loop_din(loop_din), .char_len(char_len),
      .par_en(par_en), .par_odd(par_odd), .rd_strobe(rd_strobe),
      .rx_data(rx_data), .data_ready(data_ready), .parity_err(parity_err),
      .frame_err(frame_err), .break_det(break_det), .overrun(overrun)
   );

   always #2.5 clk = ~clk;

   initial begin
      int c = 0;
      forever begin
         @(negedge clk);
         tick16 <= (c == 3);
         c = (c + 1) % 4;
      end
   end

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] mask_of(logic [1:0] len);
      return 8'hFF >> (3 - len);
   endfunction

   function automatic logic par_bit(logic [7:0] d, logic odd);
      return (^d) ^ odd;
   endfunction

   task automatic drive_bit(logic v, bit lp);
      if (lp) loop_din = v; else rx_pin = v;
      repeat (BITCLK) @(negedge clk);
   endtask

   task automatic send_frame(logic [7:0] d, logic bad_par, logic bad_stop, bit lp);
      logic [7:0] m;
      m = d & mask_of(char_len);
      drive_bit(1'b0, lp);
      for (int i = 0; i < 5 + char_len; i++) drive_bit(m[i], lp);
      if (par_en) drive_bit(par_bit(m, par_odd) ^ bad_par, lp);
      drive_bit(~bad_stop, lp);
      drive_bit(1'b1, lp);
   endtask

   task automatic do_read();
      @(negedge clk); rd_strobe = 1'b1;
      @(negedge clk); rd_strobe = 1'b0;
   endtask

   task automatic check_char(string tag, logic [7:0] d, logic bad_par, logic bad_stop);
      logic [7:0] m;
      logic pb;
      m  = d & mask_of(char_len);
      pb = par_bit(m, par_odd) ^ bad_par;
      chk({tag, " R1 R2 data"}, rx_data, m);
      chk({tag, " R7 ready"}, data_ready, 1);
      chk({tag, " R4 parity"}, parity_err, par_en & bad_par);
      chk({tag, " R5 frame"}, frame_err, bad_stop);
      chk({tag, " R6 break"}, break_det, bad_stop && m == 0 && (!par_en || pb == 0));
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      if (!ended) begin
         ended = 1;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      process::self().srandom(32'd1234);
      repeat (4) @(negedge clk);
      // R11 reset state
      chk("R11 ready", data_ready, 0);
      chk("R11 flags", {parity_err, frame_err, break_det, overrun}, 0);
      chk("R11 data", rx_data, 0);
      rst_n = 1'b1;
      repeat (BITCLK) @(negedge clk);

      // R1 R2 R4 R5 R7 random frames
      for (int n = 0; n < 60; n++) begin
         logic [7:0] d;
         logic bp, bs;
         char_len = 2'($urandom_range(0, 3));
         par_en   = 1'($urandom_range(0, 1));
         par_odd  = 1'($urandom_range(0, 1));
         d  = ($urandom_range(0, 5) == 0) ? 8'h00 : 8'($urandom);
         bp = ($urandom_range(0, 3) == 0);
         bs = ($urandom_range(0, 7) == 0);
         send_frame(d, bp, bs, 0);
         check_char("rand", d, bp, bs);
         do_read();
         chk("R7 cleared", {data_ready, parity_err, frame_err, break_det}, 0);
      end

      // R3 glitch rejected
      char_len = 2'd3; par_en = 1'b0;
      rx_pin = 1'b0;
      repeat (16) @(negedge clk);
      rx_pin = 1'b1;
      repeat (3 * BITCLK) @(negedge clk);
      chk("R3 glitch", data_ready, 0);

      // R6 break
      send_frame(8'h00, 0, 1, 0);
      check_char("brk", 8'h00, 0, 1);
      do_read();

      // R8 overrun
      char_len = 2'd2;
      send_frame(8'h15, 0, 0, 0);
      send_frame(8'h6A, 0, 0, 0);
      chk("R8 overrun", overrun, 1);
      chk("R8 newer", rx_data, 8'h6A);
      do_read();
      chk("R8 clear", overrun, 0);

      // R10 double buffer
      char_len = 2'd3;
      send_frame(8'hA5, 0, 0, 0);
      fork
         send_frame(8'h3C, 0, 0, 0);
         begin
            repeat (4 * BITCLK) @(negedge clk);
            chk("R10 held", rx_data, 8'hA5);
            do_read();
            chk("R10 read", data_ready, 0);
         end
      join
      check_char("R10 next", 8'h3C, 0, 0);
      chk("R10 no ovr", overrun, 0);
      do_read();

      // R9 loop mode, external pin held low
      loop_en = 1'b1;
      rx_pin  = 1'b0;
      par_en  = 1'b1; par_odd = 1'b1;
      send_frame(8'hC3, 0, 0, 1);
      check_char("R9 loop", 8'hC3, 0, 0);
      do_read();
      loop_en = 1'b0;
      rx_pin  = 1'b1;
      repeat (2 * BITCLK) @(negedge clk);
      chk("R9 quiet", data_ready, 0);

      if (!ended) begin
         ended = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

endmodule